// File: doc/BRIEF.md
# IDE Drive Identify Sequencer

This block brings an ATA/IDE drive out of reset and fetches its 512-byte identify block without any processor involvement. After a start pulse it drives the task-file bus through a fixed sequence. It pulses soft reset through the device control register, then sends the spin-up command. It polls the status register until the drive is ready, sends the identify command, polls again until data is offered, and then reads 256 words from the data port.

As the words go by, the block keeps two fields and drops the rest: the 40-character model label and the 32-bit total sector count. The sequence ends with one of two sticky flags. `done` means the whole block was read. `err` means the drive reported an error or a status wait ran past its limit. Every strobe is stretched over a parameterised number of clocks, so a fast system clock can still meet slow drive timing.

Top module: `ide_ident_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `ide_rd` and `ide_wr` are low, and `label` and `sectors` are zero.
- R2: After a start, the first three bus writes are control register (`ide_cs_ctl`=1, address 6) data 0x0006 (soft reset set), then control register data 0x0002 (soft reset released), then command register (`ide_cs_ctl`=0, address 7) data 0x00E1. A write only targets those two registers, and read and write strobes are never high together.
- R3: Command 0x00EC goes to address 7 only after a status read (address 7, `ide_cs_ctl`=0) returned bit 7 (busy) clear and bit 6 (ready) set. Status is read again only while that condition is not met.
- R4: The first data read (address 0) happens only after a status read following 0x00EC returned bit 7 clear and bit 3 (data request) set.
- R5: Exactly 256 data-port reads are made, and then `done` rises.
- R6: Data words 27 to 46 (byte offset 0x36) fill `label`. Word 27 goes to bits [319:304], each later word to the next 16 bits down, and the high byte of each word comes first.
- R7: `sectors` holds word 61 in bits [31:16] and word 60 in bits [15:0] (byte offset 0x78).
- R8: A status read with bit 0 (error) set, in either wait, ends the sequence at once with `err`=1. No further command is written and no data is read.
- R9: A wait fails with `err` when its status read ends at least TIMEOUT clocks after the wait began and the condition is still not met. That gives ceil((TIMEOUT+1)/(STB+1)) status reads. A wait that succeeds on its last allowed read continues normally.
- R10: Each strobe stays high for exactly STB clocks, with address stable, and is followed by at least one idle clock.
- R11: `done` and `err` are never high together, stay set while idle, and are cleared by the next start. A start while `busy` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin the sequence when idle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Identify block fully read |
| err | output | 1 | Drive error or wait timeout |
| ide_cs_ctl | output | 1 | Selects the control block (1) or command block (0) |
| ide_addr | output | 3 | Task-file register address |
| ide_wdata | output | 16 | Write data |
| ide_rdata | input | 16 | Read data from the drive |
| ide_rd | output | 1 | Read strobe, active high |
| ide_wr | output | 1 | Write strobe, active high |
| label | output | 320 | Captured model label, first character in the top byte |
| sectors | output | 32 | Captured total sector count |

## Verification
The bench builds the block with STB=2 and TIMEOUT=20. At these values a wait times out after only seven status reads, so the bench can sweep every busy-poll count up to that limit, including ready on the very last allowed poll. The two-clock strobe makes strobe width and the idle gap measurable. A drive model in the bench returns arithmetic word patterns, so the label and sector fields can be predicted for many seeds. Error and timeout faults are injected into each of the two waits.

// File: rtl/ide_ident_seq.sv
module ide_ident_seq #(
  parameter int STB       = 3,
  parameter int TIMEOUT   = 100000,
  parameter int LBL_BYTES = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic                   ide_cs_ctl,
  output logic [2:0]             ide_addr,
  output logic [15:0]            ide_wdata,
  input  logic [15:0]            ide_rdata,
  output logic                   ide_rd,
  output logic                   ide_wr,
  output logic [8*LBL_BYTES-1:0] label,
  output logic [31:0]            sectors
);
  localparam int PW        = $clog2(STB + 1);
  localparam int TW        = $clog2(TIMEOUT + 1);
  localparam int LBL_W     = 8 * LBL_BYTES;
  localparam int LPW       = $clog2(LBL_W);
  localparam int LBL_FIRST = 'h36 / 2;
  localparam int LBL_LAST  = LBL_FIRST + LBL_BYTES / 2 - 1;
  localparam int SEC_LO    = 'h78 / 2;
  localparam int SEC_HI    = SEC_LO + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_RST_ON, S_RST_OFF, S_SPIN, S_POLL_RDY, S_IDENT, S_POLL_DRQ, S_XFER
  } state_t;

  state_t          st;
  logic [PW-1:0]   ph;
  logic [TW-1:0]   tmo;
  logic [15:0]     rdq;
  logic [7:0]      widx;
  logic [LPW-1:0]  lpos;

  wire strobe = (st != S_IDLE) && (ph < PW'(STB));
  wire samp   = (st != S_IDLE) && (ph == PW'(STB - 1));
  wire fin    = ph == PW'(STB);
  wire is_wr  = st inside {S_RST_ON, S_RST_OFF, S_SPIN, S_IDENT};
  wire poll   = st inside {S_POLL_RDY, S_POLL_DRQ};
  wire s_bsy  = rdq[7];
  wire s_rdy  = rdq[6];
  wire s_drq  = rdq[3];
  wire s_err  = rdq[0];
  wire expired = tmo == TW'(TIMEOUT);
  wire in_lbl  = (widx >= 8'(LBL_FIRST)) && (widx <= 8'(LBL_LAST));

  assign busy       = st != S_IDLE;
  assign ide_wr     = strobe && is_wr;
  assign ide_rd     = strobe && !is_wr;
  assign ide_cs_ctl = (st == S_RST_ON) || (st == S_RST_OFF);
  assign ide_addr   = ide_cs_ctl ? 3'd6 : (st == S_XFER ? 3'd0 : 3'd7);
  assign lpos       = LPW'(LBL_W - 16 - 16 * (int'(widx) - LBL_FIRST));

  always_comb begin
    case (st)
      S_RST_ON:  ide_wdata = 16'h0006;
      S_RST_OFF: ide_wdata = 16'h0002;
      S_SPIN:    ide_wdata = 16'h00E1;
      S_IDENT:   ide_wdata = 16'h00EC;
      default:   ide_wdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ph      <= '0;
      tmo     <= '0;
      rdq     <= '0;
      widx    <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      label   <= '0;
      sectors <= '0;
    end else begin
      if (samp) rdq <= ide_rdata;
      ph  <= (st == S_IDLE || fin) ? '0 : ph + 1'b1;
      tmo <= !poll ? '0 : (expired ? tmo : tmo + 1'b1);
      case (st)
        S_IDLE: if (start) begin
          st      <= S_RST_ON;
          done    <= 1'b0;
          err     <= 1'b0;
          widx    <= '0;
          label   <= '0;
          sectors <= '0;
        end
        S_RST_ON:  if (fin) st <= S_RST_OFF;
        S_RST_OFF: if (fin) st <= S_SPIN;
        S_SPIN:    if (fin) st <= S_POLL_RDY;
        S_IDENT:   if (fin) st <= S_POLL_DRQ;
        S_POLL_RDY: if (fin) begin
          if (s_err) begin
            st <= S_IDLE; err <= 1'b1;
          end else if (!s_bsy && s_rdy) begin
            st <= S_IDENT;
          end else if (expired) begin
            st <= S_IDLE; err <= 1'b1;
          end
        end
        S_POLL_DRQ: if (fin) begin
          if (s_err) begin
            st <= S_IDLE; err <= 1'b1;
          end else if (!s_bsy && s_drq) begin
            st <= S_XFER;
          end else if (expired) begin
            st <= S_IDLE; err <= 1'b1;
          end
        end
        S_XFER: if (fin) begin
          if (in_lbl) label[lpos +: 16] <= rdq;
          if (widx == 8'(SEC_LO)) sectors[15:0]  <= rdq;
          if (widx == 8'(SEC_HI)) sectors[31:16] <= rdq;
          widx <= widx + 1'b1;
          if (widx == 8'd255) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ide_ident_seq_chk.sv
module ide_ident_seq_chk #(
  parameter int STB = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       ide_cs_ctl,
  input logic [2:0] ide_addr,
  input logic       ide_rd,
  input logic       ide_wr
);
  logic [7:0] hr, hw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hr <= '0;
      hw <= '0;
    end else begin
      hr <= ide_rd ? hr + 1'b1 : 8'd0;
      hw <= ide_wr ? hw + 1'b1 : 8'd0;
    end
  end

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ide_rd && ide_wr));

  assert_wr_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ide_wr |-> ((ide_cs_ctl && ide_addr == 3'd6) || (!ide_cs_ctl && ide_addr == 3'd7)));

  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ide_rd && !ide_wr));

  assert_rd_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ide_rd) |-> int'(hr) == STB);

  assert_wr_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ide_wr) |-> int'(hw) == STB);

  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ide_rd || ide_wr) && ($past(ide_rd) || $past(ide_wr))) |-> $stable(ide_addr));

  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_busy_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!done && !err));

  assert_end_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done != err));
endmodule

bind ide_ident_seq ide_ident_seq_chk #(.STB(STB)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .ide_cs_ctl(ide_cs_ctl), .ide_addr(ide_addr), .ide_rd(ide_rd), .ide_wr(ide_wr)
);

// File: tb/tb_ide_ident_seq.sv
module tb_ide_ident_seq;
  localparam int STB = 2;
  localparam int TIMEOUT = 20;
  localparam int CLKP = 20;
  localparam int TMO_POLLS = (TIMEOUT + STB + 1) / (STB + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, err, ide_cs_ctl, ide_rd, ide_wr;
  logic [2:0] ide_addr;
  logic [15:0] ide_wdata, ide_rdata;
  logic [319:0] label;
  logic [31:0] sectors;

  ide_ident_seq #(.STB(STB), .TIMEOUT(TIMEOUT), .LBL_BYTES(40)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
    .ide_cs_ctl(ide_cs_ctl), .ide_addr(ide_addr), .ide_wdata(ide_wdata),
    .ide_rdata(ide_rdata), .ide_rd(ide_rd), .ide_wr(ide_wr),
    .label(label), .sectors(sectors));

  always #(CLKP/2) clk = ~clk;

  int nchk = 0, nerr = 0;
  int nb1 = 0, nb2 = 0, errm = 0, tmom = 0;
  logic [7:0] seed = 8'h00;
  logic mclr = 1'b0;

  int p1, p2, ndata, nwr, viol, wid_bad, hc;
  logic ec_seen, prev_rd, prev_wr;
  logic [7:0] last_stat;
  logic [15:0] rdata_r;
  logic [16:0] wlog [8];

  assign ide_rdata = rdata_r;

  function automatic logic [15:0] word_of(int k, logic [7:0] s);
    return 16'((k * 257) ^ (int'(s) * 945) ^ 16'h5a00);
  endfunction

  always @(negedge clk) begin
    logic [7:0] s;
    if (mclr) begin
      p1 = 0; p2 = 0; ndata = 0; nwr = 0; viol = 0; wid_bad = 0; hc = 0;
      ec_seen = 1'b0; last_stat = 8'h00; rdata_r = 16'h0;
      for (int i = 0; i < 8; i++) wlog[i] = '0;
    end else begin
      if (ide_rd && !prev_rd) begin
        if (ide_addr == 3'd7 && !ide_cs_ctl) begin
          if (!ec_seen) begin
            if (tmom == 1 || p1 < nb1) s = 8'h80;
            else if (errm == 1) s = 8'h41;
            else s = 8'h50;
            p1++;
          end else begin
            if (tmom == 2) s = 8'h50;
            else if (p2 < nb2) s = 8'h80;
            else if (errm == 2) s = 8'h51;
            else s = 8'h58;
            p2++;
          end
          last_stat = s;
          rdata_r = {8'h00, s};
        end else if (ide_addr == 3'd0 && !ide_cs_ctl) begin
          if (!(ec_seen && last_stat == 8'h58)) viol++;
          rdata_r = word_of(ndata, seed);
          ndata++;
        end else viol++;
      end
      if (ide_wr && !prev_wr) begin
        if (nwr < 8) wlog[nwr] = {ide_cs_ctl, ide_wdata};
        nwr++;
        if (!ide_cs_ctl && ide_addr == 3'd7 && ide_wdata == 16'h00EC) begin
          if (last_stat != 8'h50) viol++;
          ec_seen = 1'b1;
        end
      end
      if (ide_rd || ide_wr) hc++;
      else begin
        if (hc != 0 && hc != STB) wid_bad++;
        hc = 0;
      end
    end
    prev_rd = ide_rd;
    prev_wr = ide_wr;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [319:0] act, input logic [319:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  task automatic run_case(input int a1, input int a2, input int ae, input int at,
                          input logic [7:0] sd);
    int cyc;
    logic [319:0] exp_lbl;
    bit normal;
    normal = (ae == 0 && at == 0);
    nb1 = a1; nb2 = a2; errm = ae; tmom = at; seed = sd;
    @(posedge clk); mclr = 1'b1;
    @(posedge clk); mclr = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !done && !err, "R11", "flags cleared by start", {busy, done, err}, 3'b100);
    cyc = 0;
    while (!(done || err) && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (normal && cyc == 30) start = 1'b1;
      if (normal && cyc == 31) start = 1'b0;
    end
    chk(cyc < 5000, "R5", "sequence completes", cyc, 5000);
    chk(wid_bad == 0, "R10", "strobe widths", wid_bad, 0);
    chk(viol == 0, "R3", "command/data ordering", viol, 0);
    chk(wlog[0] == 17'h10006 && wlog[1] == 17'h10002 && wlog[2] == 17'h000E1,
        "R2", "first three writes", {wlog[0], wlog[1], wlog[2]}, {17'h10006, 17'h10002, 17'h000E1});
    if (normal) begin
      exp_lbl = '0;
      for (int j = 0; j < 20; j++) exp_lbl[319 - 16*j -: 16] = word_of(27 + j, sd);
      chk(done && !err, "R5", "done after normal run", {done, err}, 2'b10);
      chk(ndata == 256, "R5", "data read count", ndata, 256);
      chk(nwr == 4 && wlog[3] == 17'h000EC, "R11", "write count with extra start", nwr, 4);
      chk(p1 == a1 + 1, "R3", "ready polls", p1, a1 + 1);
      chk(p2 == a2 + 1, "R4", "data-request polls", p2, a2 + 1);
      chk(label === exp_lbl, "R6", "label", label, exp_lbl);
      chk(sectors === {word_of(61, sd), word_of(60, sd)}, "R7", "sectors",
          sectors, {word_of(61, sd), word_of(60, sd)});
      repeat (10) @(negedge clk);
      chk(done && !busy && !ide_rd && !ide_wr, "R11", "done holds while idle",
          {done, busy, ide_rd, ide_wr}, 4'b1000);
    end else begin
      chk(err && !done, "R8", "error flag", {done, err}, 2'b01);
      chk(ndata == 0, "R8", "no data read after fault", ndata, 0);
      if (ae == 1) begin
        chk(nwr == 3, "R8", "no identify after error", nwr, 3);
        chk(p1 == a1 + 1, "R8", "polls before error", p1, a1 + 1);
      end
      if (ae == 2) begin
        chk(nwr == 4, "R8", "writes before data error", nwr, 4);
        chk(p2 == a2 + 1, "R8", "polls before data error", p2, a2 + 1);
      end
      if (at == 1) begin
        chk(nwr == 3, "R9", "no identify after timeout", nwr, 3);
        chk(p1 == TMO_POLLS, "R9", "ready polls until timeout", p1, TMO_POLLS);
      end
      if (at == 2) begin
        chk(nwr == 4, "R9", "writes before data timeout", nwr, 4);
        chk(p2 == TMO_POLLS, "R9", "data polls until timeout", p2, TMO_POLLS);
      end
      repeat (5) @(negedge clk);
      chk(err && !busy, "R11", "err holds while idle", {err, busy}, 2'b10);
    end
  endtask

  initial begin
    repeat (1000 * 190) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !ide_rd && !ide_wr, "R1", "reset outputs",
        {busy, done, err, ide_rd, ide_wr}, 5'b0);
    chk(label == '0 && sectors == '0, "R1", "reset fields", {label[287:0], sectors}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err, "R1", "idle after reset", {busy, done, err}, 3'b0);
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        run_case(a, b, 0, 0, 8'(a * 16 + b + 1));
    run_case(TMO_POLLS - 1, TMO_POLLS - 1, 0, 0, 8'hC3);
    for (int a = 0; a < 3; a++) begin
      run_case(a, 0, 1, 0, 8'h11);
      run_case(0, a, 2, 0, 8'h22);
    end
    run_case(0, 0, 0, 1, 8'h33);
    run_case(0, 0, 0, 2, 8'h44);
    run_case(2, 1, 0, 0, 8'hFE);
    summary();
    $finish;
  end
endmodule